// File: doc/BRIEF.md
# Measurement Scaler and Cyclic Selector

This block takes three 8-bit converter codes from a regulated supply: output voltage, load current and pass-transistor temperature. It turns one of them at a time into decimal digits in engineering units and hands a four-nibble word to a display driver. Each reading stays on the display for a fixed time slot, and the block then moves to the next reading in the order voltage, current, temperature.

The code of the reading being shown is sampled once, at the first clock of its slot, so the digits do not flicker while the slot runs. Each reading has its own full scale and decimal format. The lowest nibble carries a unit code, and leading zeros are replaced by a blank code. The decimal point is placed by the display driver from the channel number, which the block also outputs.

Top module: `meas_rotator`

## Requirements
- R1: For voltage, tenths of a volt v = (code*95 + 127) div 255. The hundreds, tens and ones digits of v (tens of volts, volts, tenths) go to nibbles [15:12], [11:8] and [7:4].
- R2: For current, hundredths of an ampere h = (code*129 + 127) div 255. The hundreds, tens and ones digits of h (amperes, tenths, hundredths) go to nibbles [15:12], [11:8] and [7:4].
- R3: For temperature, whole degrees t = (code*129 + 127) div 255. The hundreds, tens and ones digits of t go to nibbles [15:12], [11:8] and [7:4].
- R4: Nibble [3:0] holds the unit code: 4'hD for volts, 4'hE for amperes, 4'hF for degrees.
- R5: The blank code 4'hC replaces leading zeros. For voltage, nibble [15:12] is blanked when it is zero. For temperature, nibble [15:12] is blanked when the hundreds digit is zero, and nibble [11:8] is blanked when both the hundreds and tens digits are zero.
- R6: The voltage volts digit, every current digit (including the amperes digit, so 0.99 A shows 0,9,9) and the temperature ones digit are never blanked.
- R7: `disp_sel_o` steps 0 (voltage), 1 (current), 2 (temperature), 0, and so on. Each slot lasts CLK_HZ*HOLD_SEC cycles, and the first slot after reset is voltage.
- R8: The code of the channel being shown is sampled at the first clock of its slot. Input changes later in the slot do not alter the output.
- R9: `rst_ni` is asynchronous and active low, and its release is synchronised over two clocks. While the block is in reset, `disp_sel_o` is 0 and `disp_word_o` is 16'hC00D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| volt_code_i | input | 8 | Output-voltage converter code |
| amp_code_i | input | 8 | Load-current converter code |
| temp_code_i | input | 8 | Transistor-temperature converter code |
| disp_word_o | output | 16 | Three digit nibbles and a unit nibble |
| disp_sel_o | output | 2 | Channel being shown: 0 volts, 1 amperes, 2 degrees |

## Verification
Each channel is driven with code 0, code 255 and codes near digit boundaries. Current codes 196 and 197 sit on either side of 1.00 A, and temperature codes 8, 20 and 198 separate the three blanking depths from one another. While one code is being shown, the other two inputs carry different values, which exposes a wrong channel pick or a wrong slot order. Every input is then changed just after the sampling clock and the word is checked twice within the slot, which separates a held sample from a live path.

// File: rtl/meas_pkg.sv
package meas_pkg;
  typedef enum logic [1:0] {
    CH_VOLT = 2'd0,
    CH_AMP  = 2'd1,
    CH_DEG  = 2'd2
  } chan_e;

  localparam logic [3:0] NIB_BLANK = 4'hC;
  localparam logic [3:0] NIB_VOLT  = 4'hD;
  localparam logic [3:0] NIB_AMP   = 4'hE;
  localparam logic [3:0] NIB_DEG   = 4'hF;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned CODE_MAX = 255;
endpackage

// File: rtl/meas_slot_timer.sv
module meas_slot_timer
  import meas_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES = 20
) (
  input  logic       clk_i,
  input  logic       rst_n,
  output logic [1:0] sel_o,
  output logic [1:0] load_sel_o,
  output logic       load_o
);
  localparam int unsigned CW = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    sel_q, sel_d;
  logic          prime_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    sel_d = sel_q;
    if (wrap) sel_d = (sel_q == 2'd2) ? 2'd0 : sel_q + 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sel_q   <= 2'd0;
      prime_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      sel_q   <= sel_d;
      prime_q <= 1'b0;
    end
  end

  assign sel_o      = sel_q;
  assign load_sel_o = sel_d;
  assign load_o     = prime_q | wrap;

  // R7: rotation order at every slot boundary
  p_rotate_order_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap |=> (sel_q == (($past(sel_q) == 2'd2) ? 2'd0 : $past(sel_q) + 2'd1)));

  // R7: channel index stays legal
  p_sel_range_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    sel_q != 2'd3);

  // R7: slot counter never passes the last cycle of a slot
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/meas_formatter.sv
module meas_formatter
  import meas_pkg::*;
#(
  parameter int unsigned CHAN = 0
) (
  input  logic [7:0]  code_i,
  output logic [15:0] word_o
);
  localparam int unsigned FULL = (CHAN == 0) ? 95 : 129;
  localparam logic [3:0] UNIT = (CHAN == 0) ? NIB_VOLT :
                                (CHAN == 1) ? NIB_AMP  : NIB_DEG;

  logic [15:0] prod;
  logic [7:0]  scaled;
  logic [3:0]  d2, d1, d0;
  logic [3:0]  n3, n2;

  always_comb begin
    prod   = 16'(code_i) * 16'(FULL) + 16'(CODE_MAX / 2);
    scaled = 8'(prod / 16'(CODE_MAX));
    d2     = 4'(scaled / 8'd100);
    d1     = 4'((scaled / 8'd10) % 8'd10);
    d0     = 4'(scaled % 8'd10);
  end

  if (CHAN == 0) begin : g_volt
    assign n3 = (d2 == 4'd0) ? NIB_BLANK : d2;
    assign n2 = d1;
  end else if (CHAN == 1) begin : g_amp
    assign n3 = d2;
    assign n2 = d1;
  end else begin : g_deg
    assign n3 = (d2 == 4'd0) ? NIB_BLANK : d2;
    assign n2 = (d2 == 4'd0 && d1 == 4'd0) ? NIB_BLANK : d1;
  end

  assign word_o = {n3, n2, d0, UNIT};
endmodule

// File: rtl/meas_rotator.sv
module meas_rotator
  import meas_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned HOLD_SEC = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  volt_code_i,
  input  logic [7:0]  amp_code_i,
  input  logic [7:0]  temp_code_i,
  output logic [15:0] disp_word_o,
  output logic [1:0]  disp_sel_o
);
  localparam int unsigned SLOT_CYCLES = CLK_HZ * HOLD_SEC;

  logic [1:0]  rst_sync_q;
  logic        rst_n;
  logic [1:0]  sel, load_sel;
  logic        load;
  logic [7:0]  pick;
  logic [7:0]  hold_q, hold_d;
  logic [15:0] words [NUM_CH];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  meas_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .sel_o      (sel),
    .load_sel_o (load_sel),
    .load_o     (load)
  );

  always_comb begin
    case (load_sel)
      2'd1:    pick = amp_code_i;
      2'd2:    pick = temp_code_i;
      default: pick = volt_code_i;
    endcase
    hold_d = load ? pick : hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) hold_q <= 8'd0;
    else        hold_q <= hold_d;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fmt
    meas_formatter #(.CHAN(c)) u_fmt (
      .code_i (hold_q),
      .word_o (words[c])
    );
  end

  always_comb begin
    case (sel)
      2'd1:    disp_word_o = words[1];
      2'd2:    disp_word_o = words[2];
      default: disp_word_o = words[0];
    endcase
  end
  assign disp_sel_o = sel;

  // R8: sample only moves at a slot start
  p_hold_steady_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !load |=> $stable(hold_q));

  // R4: unit nibble follows the channel
  p_unit_match_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    disp_word_o[3:0] == 4'd13 + {2'b00, disp_sel_o});

  // R5: voltage never reaches ten volts, so its top nibble is blank
  p_volt_tens_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (disp_sel_o == 2'd0) |-> (disp_word_o[15:12] == NIB_BLANK));

  // R6: current amperes digit is always shown
  p_amp_ones_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (disp_sel_o == 2'd1) |-> (disp_word_o[15:12] <= 4'd1));
endmodule

// File: tb/meas_rotator_bench.sv
module meas_rotator_bench;
  localparam int SLOT  = 20;
  localparam int NSLOT = 15;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  volt_code = 8'd0, amp_code = 8'd0, temp_code = 8'd0;
  logic [15:0] disp_word;
  logic [1:0]  disp_sel;

  int checks = 0;
  int errors = 0;
  int ecnt   = 0;
  logic [17:0] sb_q [$];

  always #2.5 clk = ~clk;

  meas_rotator #(.CLK_HZ(4), .HOLD_SEC(5)) u_meas_rotator (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .volt_code_i (volt_code),
    .amp_code_i  (amp_code),
    .temp_code_i (temp_code),
    .disp_word_o (disp_word),
    .disp_sel_o  (disp_sel)
  );

  always @(posedge clk) if (rst_ni) ecnt <= ecnt + 1;

  function automatic logic [7:0] slot_code(int s);
    case (s)
      0: return 8'd0;    1: return 8'd0;    2: return 8'd0;
      3: return 8'd255;  4: return 8'd255;  5: return 8'd255;
      6: return 8'd27;   7: return 8'd196;  8: return 8'd8;
      9: return 8'd150;  10: return 8'd197; 11: return 8'd20;
      12: return 8'd101; 13: return 8'd50;  default: return 8'd198;
    endcase
  endfunction

  function automatic logic [15:0] exp_word(int ch, int code);
    int v, h, t, o;
    logic [3:0] n3, n2;
    v = (code * ((ch == 0) ? 95 : 129) + 127) / 255;
    h = v / 100; t = (v / 10) % 10; o = v % 10;
    n3 = 4'(h); n2 = 4'(t);
    if (ch != 1 && h == 0) n3 = 4'hC;
    if (ch == 2 && h == 0 && t == 0) n2 = 4'hC;
    return {n3, n2, 4'(o), 4'(13 + ch)};
  endfunction

  function automatic int cap_edge(int s);
    return (s == 0) ? 3 : s * SLOT + 2;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_slot(int s);
    logic [7:0] c;
    c = slot_code(s);
    volt_code = c ^ 8'h5A; amp_code = c ^ 8'hA5; temp_code = c ^ 8'h3C;
    case (s % 3)
      0: volt_code = c;
      1: amp_code  = c;
      default: temp_code = c;
    endcase
    sb_q.push_back({2'(s % 3), exp_word(s % 3, int'(c))});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver
  initial begin
    drive_slot(0);
    repeat (3) @(negedge clk);
    check(disp_sel == 2'd0, "R9 sel", {14'd0, disp_sel}, 16'd0);
    check(disp_word == 16'hC00D, "R9 word", disp_word, 16'hC00D);
    rst_ni = 1'b1;
    for (int s = 0; s < NSLOT; s++) begin
      if (s > 0) begin
        while (ecnt != cap_edge(s) - 1) @(negedge clk);
        drive_slot(s);
      end
      while (ecnt != cap_edge(s) + 1) @(negedge clk);
      volt_code = ~volt_code; amp_code = amp_code + 8'd77; temp_code = ~temp_code;
    end
  end

  // monitor
  initial begin
    logic [17:0] item;
    logic [15:0] ew;
    string dtag;
    for (int s = 0; s < NSLOT; s++) begin
      while (ecnt != cap_edge(s) + SLOT / 2) @(negedge clk);
      while (sb_q.size() == 0) @(negedge clk);
      item = sb_q[0];
      ew = item[15:0];
      dtag = (item[17:16] == 2'd0) ? "R1 R5 R6 digits" :
             (item[17:16] == 2'd1) ? "R2 R6 digits" : "R3 R5 R6 digits";
      check(disp_sel == item[17:16], "R7 sel", {14'd0, disp_sel}, {14'd0, item[17:16]});
      check(disp_word[3:0] == ew[3:0], "R4 unit", disp_word, ew);
      check(disp_word[15:4] == ew[15:4], dtag, disp_word, ew);
      while (ecnt != cap_edge(s) + SLOT - 3) @(negedge clk);
      check(disp_word == ew, "R8 held", disp_word, ew);
      void'(sb_q.pop_front());
    end
    finish_run();
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule